// File: doc/BRIEF.md
# RGB video output level encoder

This block is the clocked digital front end of a triple current-output video DAC. On every rising pixel clock it captures one 8-bit value each for red, green and blue, along with three control lines: a blanking request, a composite sync request, and a force-to-white overlay. For each channel it produces an integer code for the output current level. The code is the sum of weighted terms: a black-level setup pedestal, the pixel value, and, on green only, a sync current.

Levels are measured in units of one pixel LSB. The pedestal lifts black above the blanking level. The sync term raises green everywhere except at the sync tip. An analog stage downstream is expected to turn each code straight into a current. Capture is followed by a registered level stage, so an output reflects the inputs sampled two clocks earlier.

Top module: `rgb_level_enc`

## Requirements
- R1: Pixel data and all three controls are sampled together on the rising edge of `clk_i`. The level they produce appears on the outputs after the second rising edge that follows, which is a latency of two clocks.
- R2: With `white_i`=1, `blank_ni`=1 and `sync_ni`=1, red and blue output 255+PED (276 by default) whatever the pixel data, and green outputs that value plus SYNC (387 by default).
- R3: With `blank_ni`=1 and `white_i`=0, red and blue output their pixel value plus PED (default 21).
- R4: With `blank_ni`=0, red and blue output 0, and the pixel data and `white_i` have no effect.
- R5: With SYNC_ON_GREEN=1 and `sync_ni`=1, green carries an extra SYNC (default 111). With `blank_ni`=0 this makes green exactly SYNC.
- R6: With `blank_ni`=0 and `sync_ni`=0, all three outputs are 0, which is the sync tip.
- R7: With `sync_ni`=0 and `blank_ni`=1, green outputs its pixel value plus PED with no sync term, and `white_i` has no effect on any channel.
- R8: With SYNC_ON_GREEN=0, green follows the red/blue level rule exactly and never carries the sync term.
- R9: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_r_i | input | 8 | Red pixel value |
| pix_g_i | input | 8 | Green pixel value |
| pix_b_i | input | 8 | Blue pixel value |
| blank_ni | input | 1 | Blanking request, active low |
| sync_ni | input | 1 | Composite sync request, active low |
| white_i | input | 1 | Force-to-white overlay, active high |
| lvl_r_o | output | 10 | Red output level code |
| lvl_g_o | output | 10 | Green output level code |
| lvl_b_o | output | 10 | Blue output level code |

## Verification
The hardest situations to reach are those in which the force-white overlay is high but must be ignored. These are sync active during active video, and blanking with sync either active or inactive. In all of them a wrong priority still produces a plausible level on the outputs. The stimulus table sets the overlay bit in each of these rows and pairs it with non-trivial pixel data, so a leak of white or of data shows up as a wrong code. A second instance built without sync encoding receives the same stimulus, which exposes any sync term on its green output.

// File: rtl/rle_pkg.sv
package rle_pkg;
  typedef enum logic [2:0] {
    MODE_SYNC     = 3'd0,  // blank + sync active: tip
    MODE_BLANK    = 3'd1,  // blank active, sync inactive
    MODE_VIDEO_NS = 3'd2,  // video, sync active (no sync term)
    MODE_VIDEO    = 3'd3,  // video with sync term
    MODE_WHITE    = 3'd4   // forced white with sync term
  } lvl_mode_e;

  typedef struct packed {
    logic blank_n;
    logic sync_n;
    logic white;
  } ctrl_t;

  localparam int unsigned NUM_CH = 3;
  localparam int unsigned CH_G   = 1;
endpackage

// File: rtl/rle_capture.sv
module rle_capture
  import rle_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_CH-1:0][DATA_W-1:0] pix_i,
  input  ctrl_t                         ctrl_i,
  output logic [NUM_CH-1:0][DATA_W-1:0] pix_q_o,
  output ctrl_t                         ctrl_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q_o  <= '0;
      ctrl_q_o <= '{blank_n: 1'b0, sync_n: 1'b0, white: 1'b0};
    end else begin
      pix_q_o  <= pix_i;
      ctrl_q_o <= ctrl_i;
    end
  end
endmodule

// File: rtl/rle_mode_dec.sv
module rle_mode_dec
  import rle_pkg::*;
(
  input  ctrl_t     ctrl_i,
  output lvl_mode_e mode_o
);
  // blank and sync outrank the white overlay
  always_comb begin
    if (!ctrl_i.blank_n)     mode_o = ctrl_i.sync_n ? MODE_BLANK : MODE_SYNC;
    else if (!ctrl_i.sync_n) mode_o = MODE_VIDEO_NS;
    else if (ctrl_i.white)   mode_o = MODE_WHITE;
    else                     mode_o = MODE_VIDEO;
  end
endmodule

// File: rtl/rle_chan_level.sv
module rle_chan_level
  import rle_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned OUT_W    = 10,
  parameter int unsigned PED      = 21,
  parameter int unsigned SYNC_LVL = 111,
  parameter bit          HAS_SYNC = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  lvl_mode_e         mode_i,
  input  logic [DATA_W-1:0] pix_i,
  output logic [OUT_W-1:0]  lvl_o
);
  localparam logic [OUT_W-1:0] PED_C  = OUT_W'(PED);
  localparam logic [OUT_W-1:0] SYNC_C = OUT_W'(SYNC_LVL);
  localparam logic [OUT_W-1:0] FULL_C = OUT_W'((1 << DATA_W) - 1);

  logic [OUT_W-1:0] video_lvl, sync_lvl, lvl_d;
  logic             video_on, sync_on;

  always_comb begin
    video_on = (mode_i == MODE_VIDEO) || (mode_i == MODE_VIDEO_NS) ||
               (mode_i == MODE_WHITE);
    sync_on  = (mode_i == MODE_VIDEO) || (mode_i == MODE_WHITE) ||
               (mode_i == MODE_BLANK);
    video_lvl = '0;
    if (video_on)
      video_lvl = ((mode_i == MODE_WHITE) ? FULL_C : OUT_W'(pix_i)) + PED_C;
  end

  if (HAS_SYNC) begin : g_sync
    assign sync_lvl = sync_on ? SYNC_C : '0;
  end else begin : g_nosync
    assign sync_lvl = '0;
  end

  assign lvl_d = video_lvl + sync_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_o <= '0;
    else         lvl_o <= lvl_d;
  end
endmodule

// File: rtl/rgb_level_enc.sv
module rgb_level_enc
  import rle_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned OUT_W         = 10,
  parameter int unsigned PED           = 21,
  parameter int unsigned SYNC_LVL      = 111,
  parameter bit          SYNC_ON_GREEN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] pix_r_i,
  input  logic [DATA_W-1:0] pix_g_i,
  input  logic [DATA_W-1:0] pix_b_i,
  input  logic              blank_ni,
  input  logic              sync_ni,
  input  logic              white_i,
  output logic [OUT_W-1:0]  lvl_r_o,
  output logic [OUT_W-1:0]  lvl_g_o,
  output logic [OUT_W-1:0]  lvl_b_o
);
  logic [NUM_CH-1:0][DATA_W-1:0] pix_in, pix_q;
  logic [NUM_CH-1:0][OUT_W-1:0]  lvl;
  ctrl_t                         ctrl_in, ctrl_q;
  lvl_mode_e                     mode;

  assign pix_in  = {pix_b_i, pix_g_i, pix_r_i};
  assign ctrl_in = '{blank_n: blank_ni, sync_n: sync_ni, white: white_i};

  rle_capture #(.DATA_W(DATA_W)) u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pix_i   (pix_in),
    .ctrl_i  (ctrl_in),
    .pix_q_o (pix_q),
    .ctrl_q_o(ctrl_q)
  );

  rle_mode_dec u_mode_dec (
    .ctrl_i(ctrl_q),
    .mode_o(mode)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    rle_chan_level #(
      .DATA_W  (DATA_W),
      .OUT_W   (OUT_W),
      .PED     (PED),
      .SYNC_LVL(SYNC_LVL),
      .HAS_SYNC(SYNC_ON_GREEN && (c == CH_G))
    ) u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .mode_i(mode),
      .pix_i (pix_q[c]),
      .lvl_o (lvl[c])
    );
  end

  assign lvl_r_o = lvl[0];
  assign lvl_g_o = lvl[1];
  assign lvl_b_o = lvl[2];
endmodule

// File: rtl/rle_checker.sv
module rle_checker #(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned OUT_W         = 10,
  parameter int unsigned PED           = 21,
  parameter int unsigned SYNC_LVL      = 111,
  parameter bit          SYNC_ON_GREEN = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] pix_r_i,
  input logic              blank_ni,
  input logic              sync_ni,
  input logic              white_i,
  input logic [OUT_W-1:0]  lvl_r_o,
  input logic [OUT_W-1:0]  lvl_g_o,
  input logic [OUT_W-1:0]  lvl_b_o
);
  localparam logic [OUT_W-1:0] WHITE_C = OUT_W'((1 << DATA_W) - 1 + PED);

  logic [1:0] age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end
  logic warm;
  assign warm = (age == 2'd2);

  p_reset_zero_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (lvl_r_o == '0 && lvl_g_o == '0 && lvl_b_o == '0));

  p_white_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(white_i, 2) && $past(blank_ni, 2) && $past(sync_ni, 2))
    |-> (lvl_r_o == WHITE_C && lvl_b_o == WHITE_C));

  p_video_red_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(blank_ni, 2) && !$past(white_i, 2))
    |-> (lvl_r_o == OUT_W'($past(pix_r_i, 2)) + OUT_W'(PED)));

  p_blank_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && !$past(blank_ni, 2)) |-> (lvl_r_o == '0 && lvl_b_o == '0));

  p_sync_tip_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && !$past(blank_ni, 2) && !$past(sync_ni, 2)) |-> (lvl_g_o == '0));

  if (SYNC_ON_GREEN) begin : g_sog
    p_blank_green_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm && !$past(blank_ni, 2) && $past(sync_ni, 2))
      |-> (lvl_g_o == OUT_W'(SYNC_LVL)));
  end else begin : g_nosog
    p_green_like_red_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm && !$past(blank_ni, 2)) |-> (lvl_g_o == '0));
  end
endmodule

bind rgb_level_enc rle_checker #(
  .DATA_W(DATA_W), .OUT_W(OUT_W), .PED(PED), .SYNC_LVL(SYNC_LVL),
  .SYNC_ON_GREEN(SYNC_ON_GREEN)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pix_r_i(pix_r_i), .blank_ni(blank_ni),
  .sync_ni(sync_ni), .white_i(white_i), .lvl_r_o(lvl_r_o),
  .lvl_g_o(lvl_g_o), .lvl_b_o(lvl_b_o)
);

// File: tb/rgb_level_enc_bench.sv
module rgb_level_enc_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pr = '0, pg = '0, pb = '0;
  logic       bn = 1'b0, sn = 1'b0, wh = 1'b0;
  logic [9:0] lr, lg, lb, nr, ng, nb;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rgb_level_enc u_rgb_level_enc (
    .clk_i(clk), .rst_ni(rst_n), .pix_r_i(pr), .pix_g_i(pg), .pix_b_i(pb),
    .blank_ni(bn), .sync_ni(sn), .white_i(wh),
    .lvl_r_o(lr), .lvl_g_o(lg), .lvl_b_o(lb));

  rgb_level_enc #(.SYNC_ON_GREEN(1'b0)) u_rgb_level_enc_ns (
    .clk_i(clk), .rst_ni(rst_n), .pix_r_i(pr), .pix_g_i(pg), .pix_b_i(pb),
    .blank_ni(bn), .sync_ni(sn), .white_i(wh),
    .lvl_r_o(nr), .lvl_g_o(ng), .lvl_b_o(nb));

  // {r, g, b, blank_n, sync_n, white, exp_r, exp_g, exp_b}
  localparam int NV = 10;
  localparam logic [56:0] VEC [NV] = '{
    {8'h0A, 8'h14, 8'h1E, 3'b110, 10'd31,  10'd152, 10'd51},  // R3 R5
    {8'h00, 8'h00, 8'h00, 3'b110, 10'd21,  10'd132, 10'd21},  // R3 black
    {8'hFF, 8'hFF, 8'hFF, 3'b110, 10'd276, 10'd387, 10'd276}, // R3 full
    {8'h12, 8'h34, 8'h56, 3'b111, 10'd276, 10'd387, 10'd276}, // R2
    {8'h80, 8'h80, 8'h80, 3'b010, 10'd0,   10'd111, 10'd0},   // R4 R5
    {8'h80, 8'h80, 8'h80, 3'b011, 10'd0,   10'd111, 10'd0},   // R4 white ignored
    {8'h80, 8'h80, 8'h80, 3'b001, 10'd0,   10'd0,   10'd0},   // R6
    {8'h40, 8'h50, 8'h60, 3'b100, 10'd85,  10'd101, 10'd117}, // R7
    {8'h40, 8'h50, 8'h60, 3'b101, 10'd85,  10'd101, 10'd117}, // R7 white ignored
    {8'h01, 8'h02, 8'h03, 3'b110, 10'd22,  10'd134, 10'd24}   // R3
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [56:0] v);
    {pr, pg, pb, bn, sn, wh} = v[56:30];
  endtask

  // green without sync encoding follows the red/blue rule (R8)
  function automatic int nosync_g(input logic [56:0] v);
    if (!v[32]) return 0;
    if (v[31] && v[30]) return 276;
    return int'(v[48:41]) + 21;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", "r in reset", int'(lr), 0);
    chk("R9", "g in reset", int'(lg), 0);
    chk("R9", "b in reset", int'(lb), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk("R2-7 vec", $sformatf("r v%0d", i), int'(lr), int'(VEC[i][29:20]));
      chk("R5 vec",   $sformatf("g v%0d", i), int'(lg), int'(VEC[i][19:10]));
      chk("R4 vec",   $sformatf("b v%0d", i), int'(lb), int'(VEC[i][9:0]));
      chk("R8", $sformatf("nosync g v%0d", i), int'(ng), nosync_g(VEC[i]));
      chk("R8", $sformatf("nosync r v%0d", i), int'(nr), int'(VEC[i][29:20]));
    end

    // R1: two-clock latency, back to back
    drive(VEC[2]);
    @(posedge clk); @(posedge clk); @(negedge clk);
    drive(VEC[1]);
    @(posedge clk); @(negedge clk);
    chk("R1", "r one clock after", int'(lr), 276);
    drive(VEC[6]);
    @(posedge clk); @(negedge clk);
    chk("R1", "r two clocks after", int'(lr), 21);
    chk("R1", "g two clocks after", int'(lg), 132);
    @(posedge clk); @(negedge clk);
    chk("R6", "g tip next cycle", int'(lg), 0);

    // R9: asynchronous reset from a bright level
    drive(VEC[2]);
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9", "r async reset", int'(lr), 0);
    chk("R9", "g async reset", int'(lg), 0);
    chk("R9", "b async reset", int'(lb), 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule